// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer with Exception States

This block is the control state machine of a multi-cycle 32-bit processor. It steps each instruction through fetch, decode, execute, memory access and writeback, asserting the datapath controls for each step. It handles six instruction kinds: register-register (R-type), OR with an immediate, load word, store word, branch-if-equal and jump. The surrounding datapath holds PC, IR, the A and B operand registers, the ALU result register S, the memory data register, the register file, and the EPC and Cause registers. All of these are outside this block.

There are two exception paths. The first is taken by any opcode that decode does not recognise. The second is taken when the ALU reports overflow during an R-type execute step. Each exception path takes one cycle. In that cycle the ALU computes PC minus 4, and the result is written into EPC. Cause is written with a code, PC is loaded from the fixed exception vector, and no register-file or memory write is issued. The next cycle is a fetch. The controller outputs depend only on the current state, except the branch PC write, which also follows the equal flag.

State names: FETCH, DECODE, MEM_ADDR, MEM_READ, LOAD_WB, MEM_WRITE, R_EXEC, R_WB, I_EXEC, I_WB, BRANCH, JUMP, UNDEF_EXC, OVF_EXC.

Transitions:
- FETCH goes to DECODE.
- From DECODE, opcode 0x00 goes to R_EXEC, 0x23 and 0x2B go to MEM_ADDR, 0x0D goes to I_EXEC, 0x04 goes to BRANCH, 0x02 goes to JUMP, and any other opcode goes to UNDEF_EXC.
- MEM_ADDR goes to MEM_READ for 0x23 and to MEM_WRITE otherwise.
- MEM_READ goes to LOAD_WB.
- R_EXEC goes to OVF_EXC when overflow is set, and to R_WB otherwise.
- I_EXEC goes to I_WB.
- LOAD_WB, MEM_WRITE, R_WB, I_WB, BRANCH, JUMP, UNDEF_EXC and OVF_EXC all go to FETCH.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous active-low reset puts the machine in FETCH. FETCH asserts these outputs: ir_we=1, mem_rd=1, addr_sel=0, alu_a=0 (PC), alu_b=1 (constant 4), alu_op=0 (add), pc_we=1 and pc_src=0 (ALU output). All other outputs are 0.
- R2: FETCH is always followed by DECODE. DECODE asserts alu_a=0, alu_b=3 (sign-extended offset shifted left by 2) and alu_op=0, and leaves every write enable at 0. In every state, any output field that the state does not use is 0.
- R3: The opcode encodings are: R-type 0x00, load 0x23, store 0x2B, OR-immediate 0x0D, branch-equal 0x04, jump 0x02. DECODE sends every other opcode to UNDEF_EXC.
- R4: UNDEF_EXC asserts the following: alu_a=0, alu_b=1, alu_op=1 (subtract), epc_we=1, cause_we=1, cause_code=10, pc_we=1 and pc_src=3 (exception vector). It asserts rf_we=0 and mem_wr=0.
- R5: If overflow is high during R_EXEC, the next state is OVF_EXC. OVF_EXC has the same outputs as UNDEF_EXC except that cause_code=12. In that instruction the register file is never written.
- R6: Both exception states are followed by FETCH.
- R7: The overflow input is ignored in every state except R_EXEC.
- R8: R_EXEC asserts alu_a=1, alu_b=0 (B) and alu_op=2 (function field). R_WB asserts rf_we=1, rf_dst=1 (rd) and rf_src=0 (S).
- R9: I_EXEC asserts alu_a=1, alu_b=4 (zero-extended immediate) and alu_op=3 (OR). I_WB asserts rf_we=1, rf_dst=0 (rt) and rf_src=0.
- R10: MEM_ADDR asserts alu_a=1, alu_b=2 (sign-extended immediate) and alu_op=0. MEM_READ asserts mem_rd=1 and addr_sel=1. LOAD_WB asserts rf_we=1, rf_dst=0 and rf_src=1 (memory data). MEM_WRITE asserts mem_wr=1 and addr_sel=1.
- R11: BRANCH asserts alu_a=1, alu_b=0, alu_op=1 and pc_src=1 (S). pc_we is 1 only while the equal input is 1.
- R12: JUMP asserts pc_we=1 and pc_src=2 (jump target).
- R13: exc_vec_o always equals the EXC_VEC parameter, whose default is 32'h8000_0180.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| op_i | input | 6 | Opcode field of IR |
| ovf_i | input | 1 | ALU overflow flag |
| eq_i | input | 1 | ALU equal (zero) flag |
| ir_we_o | output | 1 | Load IR from memory |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 S |
| rf_we_o | output | 1 | Register-file write |
| rf_dst_o | output | 1 | Destination: 0 rt, 1 rd |
| rf_src_o | output | 1 | Write data: 0 S, 1 memory data |
| alu_a_o | output | 1 | ALU A: 0 PC, 1 A register |
| alu_b_o | output | 3 | ALU B: 0 B, 1 four, 2 sext, 3 sext<<2, 4 zext |
| alu_op_o | output | 2 | 0 add, 1 sub, 2 function field, 3 OR |
| pc_we_o | output | 1 | PC write |
| pc_src_o | output | 2 | PC source: 0 ALU, 1 S, 2 jump, 3 vector |
| epc_we_o | output | 1 | EPC write from ALU output |
| cause_we_o | output | 1 | Cause write |
| cause_code_o | output | 5 | Code written into Cause |
| exc_vec_o | output | 32 | Exception vector address for the PC mux |

## Verification
The overflow flag and the R-type writeback compete for the same clock edge. Overflow is sampled in R_EXEC, and the register write would follow one cycle later. To provoke this, the bench raises overflow in exactly the R_EXEC cycle. It then checks that the next cycle shows the overflow exception outputs with rf_we low. It also raises overflow in the decode, address, OR-execute and writeback cycles, and checks that in those cases the normal sequence and its register write are unchanged. A second race is between the equal flag and the branch PC write. Both values of the equal flag are applied in the BRANCH cycle.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int OP_W   = 6;
    localparam int CODE_W = 5;

    localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OP_W-1:0] OPC_ORIMM = 6'h0D;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;

    // ALU B operand select
    localparam logic [2:0] AB_REG  = 3'd0;
    localparam logic [2:0] AB_FOUR = 3'd1;
    localparam logic [2:0] AB_SEXT = 3'd2;
    localparam logic [2:0] AB_BOFF = 3'd3;
    localparam logic [2:0] AB_ZEXT = 3'd4;

    // ALU operation select
    localparam logic [1:0] AO_ADD   = 2'd0;
    localparam logic [1:0] AO_SUB   = 2'd1;
    localparam logic [1:0] AO_FUNCT = 2'd2;
    localparam logic [1:0] AO_OR    = 2'd3;

    // PC source select
    localparam logic [1:0] PS_ALU    = 2'd0;
    localparam logic [1:0] PS_TARGET = 2'd1;
    localparam logic [1:0] PS_JUMP   = 2'd2;
    localparam logic [1:0] PS_VEC    = 2'd3;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_MADDR, ST_MREAD, ST_LDWB, ST_MWRITE,
        ST_REXEC, ST_RWB, ST_IEXEC, ST_IWB, ST_BRANCH, ST_JUMP,
        ST_UNDEF, ST_OVFL
    } state_e;

    typedef enum logic [2:0] {
        CL_RTYPE, CL_LOAD, CL_STORE, CL_ORIMM, CL_BEQ, CL_JUMP, CL_BAD
    } iclass_e;

    typedef struct packed {
        logic              ir_we;
        logic              mem_rd;
        logic              mem_wr;
        logic              addr_sel;
        logic              rf_we;
        logic              rf_dst;
        logic              rf_src;
        logic              alu_a;
        logic [2:0]        alu_b;
        logic [1:0]        alu_op;
        logic              pc_we;
        logic [1:0]        pc_src;
        logic              epc_we;
        logic              cause_we;
        logic [CODE_W-1:0] cause_code;
    } ctl_t;

endpackage

// File: rtl/mcyc_opdec.sv
module mcyc_opdec
    import mcyc_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output iclass_e         cls_o
);
    always_comb begin
        case (op_i)
            OPC_RTYPE: cls_o = CL_RTYPE;
            OPC_LOAD:  cls_o = CL_LOAD;
            OPC_STORE: cls_o = CL_STORE;
            OPC_ORIMM: cls_o = CL_ORIMM;
            OPC_BEQ:   cls_o = CL_BEQ;
            OPC_JUMP:  cls_o = CL_JUMP;
            default:   cls_o = CL_BAD;
        endcase
    end
endmodule

// File: rtl/mcyc_nxt.sv
module mcyc_nxt
    import mcyc_pkg::*;
(
    input  state_e  state_i,
    input  iclass_e cls_i,
    input  logic    ovf_i,
    output state_e  next_o
);
    always_comb begin
        next_o = ST_FETCH;
        unique case (state_i)
            ST_FETCH:  next_o = ST_DECODE;
            ST_DECODE: begin
                unique case (cls_i)
                    CL_RTYPE: next_o = ST_REXEC;
                    CL_LOAD,
                    CL_STORE: next_o = ST_MADDR;
                    CL_ORIMM: next_o = ST_IEXEC;
                    CL_BEQ:   next_o = ST_BRANCH;
                    CL_JUMP:  next_o = ST_JUMP;
                    default:  next_o = ST_UNDEF;
                endcase
            end
            ST_MADDR:  next_o = (cls_i == CL_LOAD) ? ST_MREAD : ST_MWRITE;
            ST_MREAD:  next_o = ST_LDWB;
            // overflow only diverts the R-type path
            ST_REXEC:  next_o = ovf_i ? ST_OVFL : ST_RWB;
            ST_IEXEC:  next_o = ST_IWB;
            ST_LDWB, ST_MWRITE, ST_RWB, ST_IWB,
            ST_BRANCH, ST_JUMP, ST_UNDEF, ST_OVFL:
                       next_o = ST_FETCH;
            default:   next_o = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mcyc_outs.sv
module mcyc_outs
    import mcyc_pkg::*;
#(
    parameter logic [CODE_W-1:0] CODE_UNDEF = 5'd10,
    parameter logic [CODE_W-1:0] CODE_OVF   = 5'd12
) (
    input  state_e state_i,
    input  logic   eq_i,
    output ctl_t   ctl_o
);
    always_comb begin
        ctl_o = '0;
        unique case (state_i)
            ST_FETCH: begin
                ctl_o.ir_we  = 1'b1;
                ctl_o.mem_rd = 1'b1;
                ctl_o.alu_b  = AB_FOUR;
                ctl_o.alu_op = AO_ADD;
                ctl_o.pc_we  = 1'b1;
                ctl_o.pc_src = PS_ALU;
            end
            ST_DECODE: begin
                // branch target precomputed into S
                ctl_o.alu_b  = AB_BOFF;
                ctl_o.alu_op = AO_ADD;
            end
            ST_MADDR: begin
                ctl_o.alu_a  = 1'b1;
                ctl_o.alu_b  = AB_SEXT;
                ctl_o.alu_op = AO_ADD;
            end
            ST_MREAD: begin
                ctl_o.mem_rd   = 1'b1;
                ctl_o.addr_sel = 1'b1;
            end
            ST_LDWB: begin
                ctl_o.rf_we  = 1'b1;
                ctl_o.rf_src = 1'b1;
            end
            ST_MWRITE: begin
                ctl_o.mem_wr   = 1'b1;
                ctl_o.addr_sel = 1'b1;
            end
            ST_REXEC: begin
                ctl_o.alu_a  = 1'b1;
                ctl_o.alu_b  = AB_REG;
                ctl_o.alu_op = AO_FUNCT;
            end
            ST_RWB: begin
                ctl_o.rf_we  = 1'b1;
                ctl_o.rf_dst = 1'b1;
            end
            ST_IEXEC: begin
                ctl_o.alu_a  = 1'b1;
                ctl_o.alu_b  = AB_ZEXT;
                ctl_o.alu_op = AO_OR;
            end
            ST_IWB: begin
                ctl_o.rf_we = 1'b1;
            end
            ST_BRANCH: begin
                ctl_o.alu_a  = 1'b1;
                ctl_o.alu_b  = AB_REG;
                ctl_o.alu_op = AO_SUB;
                ctl_o.pc_we  = eq_i;
                ctl_o.pc_src = PS_TARGET;
            end
            ST_JUMP: begin
                ctl_o.pc_we  = 1'b1;
                ctl_o.pc_src = PS_JUMP;
            end
            ST_UNDEF, ST_OVFL: begin
                // ALU yields PC-4 for EPC; PC takes the vector
                ctl_o.alu_b      = AB_FOUR;
                ctl_o.alu_op     = AO_SUB;
                ctl_o.pc_we      = 1'b1;
                ctl_o.pc_src     = PS_VEC;
                ctl_o.epc_we     = 1'b1;
                ctl_o.cause_we   = 1'b1;
                ctl_o.cause_code = (state_i == ST_UNDEF) ? CODE_UNDEF : CODE_OVF;
            end
            default: ctl_o = '0;
        endcase
    end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] EXC_VEC    = 32'h8000_0180,
    parameter logic [CODE_W-1:0] CODE_UNDEF = 5'd10,
    parameter logic [CODE_W-1:0] CODE_OVF   = 5'd12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [OP_W-1:0]   op_i,
    input  logic              ovf_i,
    input  logic              eq_i,
    output logic              ir_we_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              addr_sel_o,
    output logic              rf_we_o,
    output logic              rf_dst_o,
    output logic              rf_src_o,
    output logic              alu_a_o,
    output logic [2:0]        alu_b_o,
    output logic [1:0]        alu_op_o,
    output logic              pc_we_o,
    output logic [1:0]        pc_src_o,
    output logic              epc_we_o,
    output logic              cause_we_o,
    output logic [CODE_W-1:0] cause_code_o,
    output logic [ADDR_W-1:0] exc_vec_o
);
    state_e  state_q;
    state_e  state_d;
    iclass_e cls;
    ctl_t    ctl;

    mcyc_opdec u_dec (
        .op_i  (op_i),
        .cls_o (cls)
    );

    mcyc_nxt u_nxt (
        .state_i (state_q),
        .cls_i   (cls),
        .ovf_i   (ovf_i),
        .next_o  (state_d)
    );

    mcyc_outs #(
        .CODE_UNDEF (CODE_UNDEF),
        .CODE_OVF   (CODE_OVF)
    ) u_outs (
        .state_i (state_q),
        .eq_i    (eq_i),
        .ctl_o   (ctl)
    );

    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_FETCH;
        else         state_q <= state_d;
    end

    assign ir_we_o      = ctl.ir_we;
    assign mem_rd_o     = ctl.mem_rd;
    assign mem_wr_o     = ctl.mem_wr;
    assign addr_sel_o   = ctl.addr_sel;
    assign rf_we_o      = ctl.rf_we;
    assign rf_dst_o     = ctl.rf_dst;
    assign rf_src_o     = ctl.rf_src;
    assign alu_a_o      = ctl.alu_a;
    assign alu_b_o      = ctl.alu_b;
    assign alu_op_o     = ctl.alu_op;
    assign pc_we_o      = ctl.pc_we;
    assign pc_src_o     = ctl.pc_src;
    assign epc_we_o     = ctl.epc_we;
    assign cause_we_o   = ctl.cause_we;
    assign cause_code_o = ctl.cause_code;
    assign exc_vec_o    = EXC_VEC;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk
    import mcyc_pkg::*;
#(
    parameter logic [CODE_W-1:0] OVF_CODE = 5'd12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ovf_i,
    input logic              eq_i,
    input logic              ir_we_o,
    input logic              mem_wr_o,
    input logic              addr_sel_o,
    input logic              rf_we_o,
    input logic              rf_dst_o,
    input logic              alu_a_o,
    input logic [2:0]        alu_b_o,
    input logic [1:0]        alu_op_o,
    input logic              pc_we_o,
    input logic [1:0]        pc_src_o,
    input logic              epc_we_o,
    input logic              cause_we_o,
    input logic [CODE_W-1:0] cause_code_o
);
    assert_decode_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ir_we_o |=> (!ir_we_o && alu_b_o == AB_BOFF));

    assert_exc_effects_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cause_we_o |-> (!rf_we_o && !mem_wr_o && epc_we_o && pc_we_o && pc_src_o == PS_VEC));

    assert_ovf_divert_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alu_op_o == AO_FUNCT && ovf_i) |=> (cause_we_o && cause_code_o == OVF_CODE && !rf_we_o));

    assert_exc_refetch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cause_we_o |=> ir_we_o);

    assert_ori_ignores_ovf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alu_op_o == AO_OR && ovf_i) |=> (rf_we_o && !cause_we_o));

    assert_rtype_wb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alu_op_o == AO_FUNCT && !ovf_i) |=> (rf_we_o && rf_dst_o));

    assert_store_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_wr_o |-> addr_sel_o);

    assert_branch_eq_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alu_op_o == AO_SUB && alu_a_o) |-> (pc_we_o == eq_i));
endmodule

bind mcyc_ctrl mcyc_ctrl_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ovf_i        (ovf_i),
    .eq_i         (eq_i),
    .ir_we_o      (ir_we_o),
    .mem_wr_o     (mem_wr_o),
    .addr_sel_o   (addr_sel_o),
    .rf_we_o      (rf_we_o),
    .rf_dst_o     (rf_dst_o),
    .alu_a_o      (alu_a_o),
    .alu_b_o      (alu_b_o),
    .alu_op_o     (alu_op_o),
    .pc_we_o      (pc_we_o),
    .pc_src_o     (pc_src_o),
    .epc_we_o     (epc_we_o),
    .cause_we_o   (cause_we_o),
    .cause_code_o (cause_code_o)
);

// File: tb/mcyc_ctrl_tb.sv
module mcyc_ctrl_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [5:0]  op_i = 6'h00;
    logic        ovf_i = 1'b0;
    logic        eq_i = 1'b0;
    logic        ir_we_o, mem_rd_o, mem_wr_o, addr_sel_o, rf_we_o, rf_dst_o, rf_src_o, alu_a_o;
    logic [2:0]  alu_b_o;
    logic [1:0]  alu_op_o, pc_src_o;
    logic        pc_we_o, epc_we_o, cause_we_o;
    logic [4:0]  cause_code_o;
    logic [31:0] exc_vec_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk_i = ~clk_i;   // 50 MHz

    mcyc_ctrl dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .ovf_i(ovf_i), .eq_i(eq_i),
        .ir_we_o(ir_we_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
        .addr_sel_o(addr_sel_o), .rf_we_o(rf_we_o), .rf_dst_o(rf_dst_o),
        .rf_src_o(rf_src_o), .alu_a_o(alu_a_o), .alu_b_o(alu_b_o),
        .alu_op_o(alu_op_o), .pc_we_o(pc_we_o), .pc_src_o(pc_src_o),
        .epc_we_o(epc_we_o), .cause_we_o(cause_we_o),
        .cause_code_o(cause_code_o), .exc_vec_o(exc_vec_o)
    );

    // bench phases
    localparam int P_F = 0, P_D = 1, P_MA = 2, P_MR = 3, P_LW = 4, P_MW = 5, P_RX = 6,
                   P_RW = 7, P_IX = 8, P_IW = 9, P_BR = 10, P_J = 11, P_UD = 12, P_OV = 13;

    // {opcode, ovf step (F = none), eq, expected cycles}
    localparam int N_VEC = 16;
    localparam logic [14:0] VEC [N_VEC] = '{
        {6'h00, 4'hF, 1'b0, 4'd4},  // R8 R-type
        {6'h00, 4'd2, 1'b0, 4'd4},  // R5 overflow in execute
        {6'h00, 4'd1, 1'b0, 4'd4},  // R7 ovf in decode ignored
        {6'h00, 4'd3, 1'b0, 4'd4},  // R7 ovf in writeback ignored
        {6'h23, 4'hF, 1'b0, 4'd5},  // R10 load
        {6'h23, 4'd2, 1'b0, 4'd5},  // R7 ovf on address add ignored
        {6'h2B, 4'hF, 1'b0, 4'd4},  // R10 store
        {6'h0D, 4'hF, 1'b0, 4'd4},  // R9 or-immediate
        {6'h0D, 4'd2, 1'b0, 4'd4},  // R7 ovf on OR ignored
        {6'h04, 4'hF, 1'b1, 4'd3},  // R11 taken
        {6'h04, 4'hF, 1'b0, 4'd3},  // R11 not taken
        {6'h02, 4'hF, 1'b0, 4'd3},  // R12 jump
        {6'h3F, 4'hF, 1'b0, 4'd3},  // R3 undefined
        {6'h05, 4'hF, 1'b0, 4'd3},  // R3 undefined next to beq
        {6'h01, 4'd2, 1'b0, 4'd3},  // R4 undefined, ovf ignored
        {6'h00, 4'd2, 1'b1, 4'd4}   // R6 overflow right after exception
    };

    function automatic logic [22:0] exp_ctl(int ph, logic eq);
        logic ir, mrd, mwr, asel, rfwe, rfdst, rfsrc, alua, pcwe, epc, cwe;
        logic [2:0] b;
        logic [1:0] o, ps;
        logic [4:0] code;
        {ir, mrd, mwr, asel, rfwe, rfdst, rfsrc, alua, pcwe, epc, cwe} = '0;
        b = 3'd0; o = 2'd0; ps = 2'd0; code = 5'd0;
        case (ph)
            P_F:  begin ir = 1; mrd = 1; b = 3'd1; pcwe = 1; end
            P_D:  b = 3'd3;
            P_MA: begin alua = 1; b = 3'd2; end
            P_MR: begin mrd = 1; asel = 1; end
            P_LW: begin rfwe = 1; rfsrc = 1; end
            P_MW: begin mwr = 1; asel = 1; end
            P_RX: begin alua = 1; o = 2'd2; end
            P_RW: begin rfwe = 1; rfdst = 1; end
            P_IX: begin alua = 1; b = 3'd4; o = 2'd3; end
            P_IW: rfwe = 1;
            P_BR: begin alua = 1; o = 2'd1; pcwe = eq; ps = 2'd1; end
            P_J:  begin pcwe = 1; ps = 2'd2; end
            P_UD, P_OV: begin
                b = 3'd1; o = 2'd1; pcwe = 1; ps = 2'd3; epc = 1; cwe = 1;
                code = (ph == P_UD) ? 5'd10 : 5'd12;
            end
            default: ;
        endcase
        return {ir, mrd, mwr, asel, rfwe, rfdst, rfsrc, alua, b, o, pcwe, ps, epc, cwe, code};
    endfunction

    function automatic int next_ph(int ph, logic [5:0] op, logic ovf);
        case (ph)
            P_F: return P_D;
            P_D: case (op)
                     6'h00: return P_RX;
                     6'h23, 6'h2B: return P_MA;
                     6'h0D: return P_IX;
                     6'h04: return P_BR;
                     6'h02: return P_J;
                     default: return P_UD;
                 endcase
            P_MA: return (op == 6'h23) ? P_MR : P_MW;
            P_MR: return P_LW;
            P_RX: return ovf ? P_OV : P_RW;
            P_IX: return P_IW;
            default: return P_F;
        endcase
    endfunction

    function automatic string ptag(int ph);
        case (ph)
            P_F: return "R1";
            P_D: return "R2";
            P_MA, P_MR, P_LW, P_MW: return "R10";
            P_RX, P_RW: return "R8";
            P_IX, P_IW: return "R9";
            P_BR: return "R11";
            P_J: return "R12";
            P_UD: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [22:0] act_ctl();
        return {ir_we_o, mem_rd_o, mem_wr_o, addr_sel_o, rf_we_o, rf_dst_o, rf_src_o,
                alu_a_o, alu_b_o, alu_op_o, pc_we_o, pc_src_o, epc_we_o, cause_we_o, cause_code_o};
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
    endtask

    initial begin
        logic [5:0] op;
        logic [3:0] ostep, len;
        logic       e;
        int         ph, steps;
        repeat (2) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        #2;
        chk(act_ctl() == exp_ctl(P_F, 1'b0), "R1 reset", {9'd0, act_ctl()}, {9'd0, exp_ctl(P_F, 1'b0)});
        chk(exc_vec_o == 32'h8000_0180, "R13 vector", exc_vec_o, 32'h8000_0180);
        #1;
        for (int v = 0; v < N_VEC; v++) begin
            {op, ostep, e, len} = VEC[v];
            ph = P_F;
            steps = 0;
            do begin
                op_i = op;
                ovf_i = (steps == int'(ostep));
                eq_i = e;
                #2;
                chk(act_ctl() == exp_ctl(ph, e), ptag(ph), {9'd0, act_ctl()}, {9'd0, exp_ctl(ph, e)});
                ph = next_ph(ph, op, ovf_i);
                steps++;
                @(negedge clk_i);
            end while (ph != P_F && steps < 8);
            // R3 R6 R7: sequence length and return to fetch
            chk(steps == int'(len), "R3 R6 R7 length", steps, {28'd0, len});
        end
        // R1: reset taken in the middle of an instruction
        ovf_i = 1'b0;
        op_i = 6'h23;
        #2;
        chk(ir_we_o == 1'b1, "R1 fetch before reset", ir_we_o, 1);
        @(negedge clk_i);
        rst_ni = 1'b0;
        #2;
        chk(act_ctl() == exp_ctl(P_D, 1'b0), "R2 decode", {9'd0, act_ctl()}, {9'd0, exp_ctl(P_D, 1'b0)});
        @(negedge clk_i);
        #2;
        chk(act_ctl() == exp_ctl(P_F, 1'b0), "R1 mid reset", {9'd0, act_ctl()}, {9'd0, exp_ctl(P_F, 1'b0)});
        rst_ni = 1'b1;
        @(negedge clk_i);
        #2;
        chk(act_ctl() == exp_ctl(P_D, 1'b0), "R2 after reset", {9'd0, act_ctl()}, {9'd0, exp_ctl(P_D, 1'b0)});
        chk(exc_vec_o == 32'h8000_0180, "R13 vector end", exc_vec_o, 32'h8000_0180);
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end
endmodule